// File: doc/BRIEF.md
# Synchronous Tag Memory with Word Comparator

This block is a single-port synchronous memory of configurable depth holding 18-bit words, each made of two 9-bit lanes. Address, write data, the three select inputs and all write controls are captured on the rising clock edge. Besides ordinary reads and lane-granular writes, it offers a compare access. In that access the word presented on the data input is registered and checked against the stored word, and a single match flag reports whether the two are equal. The read data stays hidden during a compare.

A static timing input picks one of two output timings. In flow-through timing, read data and the match flag of an access appear right after the edge that samples the access. In pipelined timing, they appear one edge later. Two asynchronous enables gate the read-data outputs and the match output. The gated outputs are modelled as a data bus with a valid flag and a plain match bit, not as tri-state drivers. Burst address sequencing is left to a neighbouring block, which drives the address directly.

Top module: `tag_sram_cmp`

## Requirements
- R1: A word is 18 bits; lane k occupies bits [9k+8:9k], and lane_sel[k] names lane k (lane 0 is bits 8:0, lane 1 is bits 17:9).
- R2: Without global write, lane k is written only when lane_wr_en is high and lane_sel[k] is high; other lanes keep their stored value.
- R3: When all_wr is high, both lanes are written from din, whatever lane_wr_en and lane_sel are.
- R4: The device is selected only when sel0_n=0, sel1=1 and sel2_n=0. An access sampled while unselected writes nothing, and its result slot shows dout=0, dout_vld=0 and match=0.
- R5: A selected access with cmp_req high and no lane requested for writing is a compare. din is registered regardless of din_en, dout_vld stays 0 for that result slot, and match is 1 exactly when the stored word equals the registered din.
- R6: With mode_pipe=0 the result of an access sampled at edge N is on the outputs from just after edge N until edge N+1. With mode_pipe=1 it is there from just after edge N+1 until edge N+2.
- R7: oe=0 forces dout=0 and dout_vld=0, and moe=0 forces match=0, both without waiting for a clock edge.
- R8: A selected access that requests a lane write while din_en is low leaves the memory unchanged and produces no read result (dout_vld=0, match=0 in its slot).
- R9: A read sampled at the edge right after a write to the same address returns the merged word: new lanes from the write, old lanes from before.
- R10: While and right after reset, dout=0, dout_vld=0 and match=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the output state |
| mode_pipe | input | 1 | 1: pipelined output timing, 0: flow-through |
| sel0_n | input | 1 | Select input, active low |
| sel1 | input | 1 | Select input, active high |
| sel2_n | input | 1 | Select input, active low |
| addr | input | ADDR_W (8) | Word address |
| din | input | 18 | Write data or compare data |
| din_en | input | 1 | Allows write data into the array |
| all_wr | input | 1 | Writes every lane |
| lane_wr_en | input | 1 | Qualifies the per-lane selects |
| lane_sel | input | 2 | Per-lane write selects |
| cmp_req | input | 1 | Requests a compare instead of a read |
| oe | input | 1 | Asynchronous data output enable |
| moe | input | 1 | Asynchronous match output enable |
| dout | output | 18 | Read data, zero when not valid or not enabled |
| dout_vld | output | 1 | Read data valid |
| match | output | 1 | Compare result |

## Verification
A corrupted stored word or a lane written that should not have been shows at the ports at the next read or compare of that address. In flow-through timing that is the same cycle; pipelined, it is one cycle later. The bench therefore revisits a small address set often and compares every output slot. A stale access-stage register, such as an operation code that survives a deselect, shows at once as a spurious dout_vld or match in the slot of that access. A wrong pipeline register shows as a result one cycle early or late once the timing input is switched.

// File: rtl/tag_sram_pkg.sv
package tag_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_CMP   = 2'd2,
    OP_WRITE = 2'd3
  } op_e;
endpackage

// File: rtl/tag_sram_ctrl.sv
module tag_sram_ctrl
  import tag_sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             all_wr,
  input  logic             lane_wr_en,
  input  logic [LANES-1:0] lane_sel,
  input  logic             din_en,
  input  logic             cmp_req,
  output logic             selected,
  output logic [LANES-1:0] wr_mask,
  output op_e              op
);
  // Lanes a cycle asks to write, before select and data-enable qualification.
  function automatic logic [LANES-1:0] req_lanes_f(input logic g, input logic en,
                                                   input logic [LANES-1:0] s);
    if (g) return '1;
    if (en) return s;
    return '0;
  endfunction

  logic [LANES-1:0] req_mask;

  assign selected = !sel0_n && sel1 && !sel2_n;
  assign req_mask = req_lanes_f(all_wr, lane_wr_en, lane_sel);

  always_comb begin
    if (!selected)        op = OP_NONE;
    else if (|req_mask)   op = din_en ? OP_WRITE : OP_NONE;
    else if (cmp_req)     op = OP_CMP;
    else                  op = OP_READ;
  end

  assign wr_mask = (op == OP_WRITE) ? req_mask : '0;

  a_r8_no_write_without_de: assert property (@(posedge clk) disable iff (!rst_n)
    !din_en |-> (wr_mask == '0));
  a_r3_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && all_wr && din_en) |-> (wr_mask == '1));
endmodule

// File: rtl/tag_sram_array.sv
module tag_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_mask[k]) store[wr_addr] <= wr_word[k*LANE_W +: LANE_W];
    end
    assign rd_word[k*LANE_W +: LANE_W] = store[rd_addr];
  end
endmodule

// File: rtl/tag_sram_outstage.sv
module tag_sram_outstage
  import tag_sram_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pipe,
  input  op_e               op_q,
  input  logic [WORD_W-1:0] rd_word,
  input  logic [WORD_W-1:0] cmp_q,
  input  logic              oe,
  input  logic              moe,
  output logic [WORD_W-1:0] dout,
  output logic              dout_vld,
  output logic              match
);
  function automatic logic word_eq_f(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  logic              ft_vld, ft_match;
  logic [WORD_W-1:0] ft_data;
  logic              p_vld, p_match;
  logic [WORD_W-1:0] p_data;
  logic              res_vld, res_match;
  logic [WORD_W-1:0] res_data;

  assign ft_vld   = (op_q == OP_READ);
  assign ft_data  = ft_vld ? rd_word : '0;
  assign ft_match = (op_q == OP_CMP) && word_eq_f(rd_word, cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld   <= 1'b0;
      p_data  <= '0;
      p_match <= 1'b0;
    end else begin
      p_vld   <= ft_vld;
      p_data  <= ft_data;
      p_match <= ft_match;
    end
  end

  assign res_vld   = mode_pipe ? p_vld   : ft_vld;
  assign res_data  = mode_pipe ? p_data  : ft_data;
  assign res_match = mode_pipe ? p_match : ft_match;

  assign dout_vld = oe && res_vld;
  assign dout     = dout_vld ? res_data : '0;
  assign match    = moe && res_match;

  a_r7_match_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !moe |-> !match);
  a_r6_pipe_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pipe && $past(mode_pipe) && oe) |-> (dout_vld == $past(ft_vld)));
  a_r5_cmp_hides_data: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_q == OP_CMP) && !mode_pipe) |-> !dout_vld);
endmodule

// File: rtl/tag_sram_cmp.sv
module tag_sram_cmp
  import tag_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pipe,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  input  logic              din_en,
  input  logic              all_wr,
  input  logic              lane_wr_en,
  input  logic [LANES-1:0]  lane_sel,
  input  logic              cmp_req,
  input  logic              oe,
  input  logic              moe,
  output logic [WORD_W-1:0] dout,
  output logic              dout_vld,
  output logic              match
);
  logic              selected;
  logic [LANES-1:0]  wr_mask;
  op_e               op, op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] cmp_q;
  logic [WORD_W-1:0] rd_word;

  tag_sram_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .all_wr(all_wr), .lane_wr_en(lane_wr_en), .lane_sel(lane_sel),
    .din_en(din_en), .cmp_req(cmp_req),
    .selected(selected), .wr_mask(wr_mask), .op(op)
  );

  tag_sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .wr_mask(wr_mask), .wr_addr(addr), .wr_word(din),
    .rd_addr(addr_q), .rd_word(rd_word)
  );

  // Access stage: what the last sampled edge asked for.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
      cmp_q  <= '0;
    end else begin
      op_q   <= op;
      addr_q <= addr;
      if (op == OP_CMP) cmp_q <= din;
    end
  end

  tag_sram_outstage #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .op_q(op_q),
    .rd_word(rd_word), .cmp_q(cmp_q), .oe(oe), .moe(moe),
    .dout(dout), .dout_vld(dout_vld), .match(match)
  );

  a_r4_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!selected && !mode_pipe) |=> (mode_pipe || (!dout_vld && !match)));
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!dout_vld && !match && (dout == '0)));
endmodule

// File: tb/tag_sram_cmp_bench.sv
module tag_sram_cmp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_pipe = 1'b0;
  logic        sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
  logic [7:0]  addr = '0;
  logic [17:0] din = '0;
  logic        din_en = 1'b0, all_wr = 1'b0, lane_wr_en = 1'b0, cmp_req = 1'b0;
  logic [1:0]  lane_sel = '0;
  logic        oe = 1'b1, moe = 1'b1;
  logic [17:0] dout;
  logic        dout_vld, match;

  int checks = 0;
  int errors = 0;

  logic [17:0] mdl [256];
  logic        pv = 1'b0, pm = 1'b0;
  logic [17:0] pd = '0;

  always #10 clk = ~clk;

  tag_sram_cmp u_tag_sram_cmp (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .addr(addr), .din(din), .din_en(din_en), .all_wr(all_wr),
    .lane_wr_en(lane_wr_en), .lane_sel(lane_sel), .cmp_req(cmp_req),
    .oe(oe), .moe(moe), .dout(dout), .dout_vld(dout_vld), .match(match)
  );

  function automatic logic sel_ok(input logic a_n, input logic b, input logic c_n);
    return ({a_n, b, c_n} == 3'b010);
  endfunction

  function automatic logic [1:0] lanes_of(input logic g, input logic en, input logic [1:0] s);
    logic [1:0] r;
    r = s & {2{en}};
    r = r | {2{g}};
    return r;
  endfunction

  task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got vld=%0b dout=%05h match=%0b expected vld=%0b dout=%05h match=%0b",
               tag, got[19], got[18:1], got[0], exp[19], exp[18:1], exp[0]);
    end
  endtask

  function automatic logic [19:0] gate(input logic v, input logic [17:0] d, input logic m);
    logic vv;
    vv = v && oe;
    return {vv, vv ? d : 18'h0, m && moe};
  endfunction

  task automatic tick(input string tag);
    logic s_sel, s_de, s_cmp, fv, fm;
    logic [1:0] s_m;
    logic [7:0] s_a;
    logic [17:0] s_d, fd;
    logic [19:0] e;
    s_sel = sel_ok(sel0_n, sel1, sel2_n);
    s_m   = lanes_of(all_wr, lane_wr_en, lane_sel);
    s_de  = din_en; s_cmp = cmp_req; s_a = addr; s_d = din;
    @(posedge clk);
    @(negedge clk);
    fv = 1'b0; fm = 1'b0; fd = '0;
    if (s_sel) begin
      if (s_m != 2'b00) begin
        if (s_de) begin
          if (s_m[0]) mdl[s_a][8:0]  = s_d[8:0];
          if (s_m[1]) mdl[s_a][17:9] = s_d[17:9];
        end
      end else if (s_cmp) begin
        fm = (mdl[s_a] == s_d);
      end else begin
        fv = 1'b1; fd = mdl[s_a];
      end
    end
    e = mode_pipe ? gate(pv, pd, pm) : gate(fv, fd, fm);
    check(tag, {dout_vld, dout, match}, e);
    pv = fv; pd = fd; pm = fm;
  endtask

  task automatic setup(input logic on, input logic [7:0] a, input logic [17:0] d,
                       input logic g, input logic en, input logic [1:0] s,
                       input logic de, input logic c);
    if (on) begin sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0; end
    addr = a; din = d; all_wr = g; lane_wr_en = en; lane_sel = s;
    din_en = de; cmp_req = c;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    setup(1'b1, a, 18'h0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    tick(tag);
  endtask

  task automatic directed(input string sfx);
    // R1 / R2: lane 0 only, lane 1 kept.
    setup(1'b1, 8'd5, 18'h3FFFF, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0); tick("R2");
    rd(8'd5, "R2");
    // R1: lane 1 at bits 17:9.
    setup(1'b1, 8'd4, 18'h2AA55, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0); tick("R1");
    rd(8'd4, "R1");
    // R2: enable low with selects set writes nothing.
    setup(1'b1, 8'd4, 18'h00000, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0); tick("R2");
    rd(8'd4, "R2");
    // R3: global write ignores lane selects.
    setup(1'b1, 8'd6, 18'h1C3A5, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0); tick("R3");
    rd(8'd6, "R3");
    // R8: write request with data enable low.
    setup(1'b1, 8'd7, 18'h12345, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0); tick("R8");
    rd(8'd7, "R8");
    // R9: write then immediate read, merged lanes.
    setup(1'b1, 8'd9, 18'h3FE00, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0); tick("R9");
    rd(8'd9, "R9");
    // R5: compare hit and miss.
    setup(1'b1, 8'd6, 18'h1C3A5, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1); tick("R5");
    setup(1'b1, 8'd6, 18'h1C3A4, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1); tick("R5");
    rd(8'd6, "R5");
    // R4: each select input alone deselects.
    for (int k = 0; k < 3; k++) begin
      setup(1'b1, 8'd6, 18'h00000, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0);
      if (k == 0) sel0_n = 1'b1;
      if (k == 1) sel1 = 1'b0;
      if (k == 2) sel2_n = 1'b1;
      tick("R4");
      tick("R4");
      rd(8'd6, "R4");
    end
    // R7: enables gate outputs.
    oe = 1'b0; rd(8'd6, "R7");
    oe = 1'b1; moe = 1'b0;
    setup(1'b1, 8'd6, mdl[6], 1'b0, 1'b0, 2'b00, 1'b0, 1'b1); tick("R7");
    moe = 1'b1;
    rd(8'd6, "R7");
    $display("directed pass %s done", sfx);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog R6 got hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", {dout_vld, dout, match}, 20'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {dout_vld, dout, match}, 20'h0);

    // Fill every word with a global write.
    for (int i = 0; i < 256; i++) begin
      setup(1'b1, 8'(i), 18'($urandom), 1'b1, 1'b0, 2'b00, 1'b1, 1'b0);
      tick("R3");
    end

    mode_pipe = 1'b0;
    directed("flow");
    // R7 without a clock edge: toggle oe mid-cycle after a flow read.
    rd(8'd5, "R7");
    oe = 1'b0; #2;
    check("R7", {dout_vld, dout, match}, 20'h0);
    oe = 1'b1; #2;
    check("R7", {dout_vld, dout, match}, {1'b1, mdl[5], 1'b0});

    mode_pipe = 1'b1;
    directed("pipe");
    // R6: pipelined read shows one slot late.
    rd(8'd9, "R6");
    setup(1'b0, 8'd0, 18'h0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    sel0_n = 1'b1; sel1 = 1'b0;
    tick("R6");
    check("R6", {dout_vld, dout, match}, {1'b1, mdl[9], 1'b0});

    for (int blk = 0; blk < 16; blk++) begin
      mode_pipe = 1'($urandom);
      for (int j = 0; j < 100; j++) begin
        logic [7:0] a;
        logic [17:0] d;
        a = 8'($urandom_range(0, 15));
        d = ($urandom % 2 == 0) ? mdl[a] : 18'($urandom);
        setup(($urandom % 8) != 0, a, d, ($urandom % 4) == 0, 1'($urandom),
              2'($urandom), ($urandom % 5) != 0, 1'($urandom));
        if (($urandom % 8) == 0) begin sel0_n = 1'b1; sel1 = 1'($urandom); end
        oe  = ($urandom % 6) != 0;
        moe = ($urandom % 6) != 0;
        tick("R6");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule